// File: doc/BRIEF.md
# Bridge Secondary Status Register

This block holds the 16-bit secondary-side error status word of a virtual PCI-to-PCI bridge that sits inside a host controller. A packet decoder upstream of it reports each received transaction-layer packet as a set of single-cycle strobes and qualifiers: a strobe for every packet with its poison (EP) flag, a strobe for received messages with the message kind, and a strobe for received completions. The completion strobe comes with the 3-bit completion status, a flag saying whether the bridge itself issued the request, and a flag saying whether the completion carries read data. From these inputs the block sets five sticky status bits. One of those bits is gated by the parity-error-response enable from the bridge control register.

Software reads the word through a configuration access port and clears bits by writing ones to them. Each of the two bytes has its own byte enable. The read data is the registered value, so an event is visible on the read port from the cycle after its strobe. The bits that are not implemented read as zero, and writes to them are ignored.

Top module: `bss_top`

## Requirements
- R1: While reset is high, the register becomes 0000h on the next clock edge, and every bit reads 0 after reset.
- R2: Bit 15 is set by any packet strobe (`rx_tlp_valid`=1) with `rx_poisoned`=1, whatever the value of `par_resp_en`.
- R3: Bit 14 is set by a message strobe whose `msg_kind` is 2'b10 (non-fatal error) or 2'b11 (fatal error). Kinds 2'b00 (other) and 2'b01 (correctable) have no effect.
- R4: Bit 13 is set by a completion strobe with status 3'b001 (Unsupported Request) and `cpl_own_req`=1. If `cpl_own_req`=0 or the status differs, it has no effect.
- R5: Bit 12 is set by a completion strobe with status 3'b100 (Completer Abort) and `cpl_own_req`=1. If `cpl_own_req`=0 or the status differs, it has no effect.
- R6: Bit 8 is set only when one cycle has all of these: the packet strobe, `rx_poisoned`=1, the completion strobe, `cpl_rd_data`=1 and `par_resp_en`=1.
- R7: Bits 11:9 and 7:0 always read 0, and writes to them have no effect.
- R8: A configuration write clears each implemented bit written as 1 and leaves unchanged each bit written as 0.
- R9: `cfg_be[1]` qualifies bits 15:8 and `cfg_be[0]` qualifies bits 7:0. A byte whose enable is 0 is not changed by the write.
- R10: When a set event and a clearing write hit the same bit in the same cycle, the bit ends at 1.
- R11: A set bit stays 1 until it is cleared or reset. `cfg_rdata` shows the value from before the current cycle's events, so a bit appears on the read port one cycle after its event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_tlp_valid | input | 1 | Strobe: a packet was received this cycle |
| rx_poisoned | input | 1 | EP flag of the received packet |
| msg_valid | input | 1 | Strobe: the received packet is a message |
| msg_kind | input | 2 | 00 other, 01 correctable, 10 non-fatal, 11 fatal |
| cpl_valid | input | 1 | Strobe: the received packet is a completion |
| cpl_status | input | 3 | Completion status (000 success, 001 UR, 010 retry, 100 CA) |
| cpl_own_req | input | 1 | Completion answers a request the bridge issued |
| cpl_rd_data | input | 1 | Completion carries read data |
| par_resp_en | input | 1 | Parity-error-response enable from bridge control |
| cfg_wr | input | 1 | Configuration write to this register |
| cfg_be | input | 2 | Byte enables, bit 0 for the low byte |
| cfg_wdata | input | 16 | Write data, 1 clears a bit |
| cfg_rdata | output | 16 | Current register value |

## Verification
The assertions assume that the completion and message strobes come only with the packet strobe, and that each input strobe is a single-cycle event held stable between clock edges. They do not assume that the qualifier inputs are zero when no strobe is active. The bench drives every input at the falling edge and runs through all 4096 combinations of the event inputs, including cases where a qualifier is set without its strobe. So an assertion on any bit's set condition sees every legal and idle input pattern. Write sweeps cover all byte-enable pairs and all clear masks over the five implemented bits. In those sweeps the reserved bits are filled with ones.

// File: rtl/bss_pkg.sv
package bss_pkg;

    localparam int REG_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int NBYTES  = REG_W / BYTE_W;

    localparam int POS_POISON_SEEN = 15;
    localparam int POS_SYS_ERR     = 14;
    localparam int POS_UR_ABORT    = 13;
    localparam int POS_CA_ABORT    = 12;
    localparam int POS_RD_POISON   = 8;

    localparam logic [REG_W-1:0] IMPL_MASK =
        (REG_W'(1) << POS_POISON_SEEN) | (REG_W'(1) << POS_SYS_ERR) |
        (REG_W'(1) << POS_UR_ABORT)    | (REG_W'(1) << POS_CA_ABORT) |
        (REG_W'(1) << POS_RD_POISON);

    typedef enum logic [2:0] {
        CPL_SC  = 3'b000,
        CPL_UR  = 3'b001,
        CPL_CRS = 3'b010,
        CPL_CA  = 3'b100
    } cpl_stat_e;

    typedef enum logic [1:0] {
        MSG_OTHER    = 2'b00,
        MSG_CORR     = 2'b01,
        MSG_NONFATAL = 2'b10,
        MSG_FATAL    = 2'b11
    } msg_kind_e;

    typedef struct packed {
        logic poison_seen;
        logic sys_err;
        logic ur_abort;
        logic ca_abort;
        logic rd_poison;
    } evt_t;

    function automatic logic [REG_W-1:0] evt_to_vec(evt_t e);
        logic [REG_W-1:0] v;
        v = '0;
        v[POS_POISON_SEEN] = e.poison_seen;
        v[POS_SYS_ERR]     = e.sys_err;
        v[POS_UR_ABORT]    = e.ur_abort;
        v[POS_CA_ABORT]    = e.ca_abort;
        v[POS_RD_POISON]   = e.rd_poison;
        return v;
    endfunction

endpackage

// File: rtl/bss_event_decode.sv
module bss_event_decode
    import bss_pkg::*;
(
    input  logic       rx_tlp_valid,
    input  logic       rx_poisoned,
    input  logic       msg_valid,
    input  logic [1:0] msg_kind,
    input  logic       cpl_valid,
    input  logic [2:0] cpl_status,
    input  logic       cpl_own_req,
    input  logic       cpl_rd_data,
    input  logic       par_resp_en,
    output evt_t       evt
);

    msg_kind_e kind;
    cpl_stat_e stat;
    logic      own_cpl;
    logic      err_msg;

    always_comb begin
        kind    = msg_kind_e'(msg_kind);
        stat    = cpl_stat_e'(cpl_status);
        own_cpl = cpl_valid && cpl_own_req;
        err_msg = (kind == MSG_NONFATAL) || (kind == MSG_FATAL);

        evt.poison_seen = rx_tlp_valid && rx_poisoned;
        evt.sys_err     = msg_valid && err_msg;
        evt.ur_abort    = own_cpl && (stat == CPL_UR);
        evt.ca_abort    = own_cpl && (stat == CPL_CA);
        evt.rd_poison   = rx_tlp_valid && rx_poisoned && cpl_valid &&
                          cpl_rd_data && par_resp_en;
    end

endmodule

// File: rtl/bss_status_store.sv
module bss_status_store
    import bss_pkg::*;
#(
    parameter int W = REG_W,
    parameter int BW = BYTE_W,
    parameter logic [W-1:0] STICKY_MASK = IMPL_MASK,
    localparam int NB = W / BW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [W-1:0]  set_vec,
    input  logic          wr,
    input  logic [NB-1:0] be,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  q
);

    logic [W-1:0] clr_vec;
    logic [W-1:0] q_nxt;

    for (genvar b = 0; b < NB; b++) begin : g_byte
        always_comb begin
            clr_vec[b*BW +: BW] = (wr && be[b]) ? wdata[b*BW +: BW] : '0;
        end
    end

    always_comb begin
        q_nxt = ((q & ~clr_vec) | set_vec) & STICKY_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= q_nxt;
    end

    for (genvar i = 0; i < W; i++) begin : g_chk
        if (STICKY_MASK[i]) begin : g_impl
            AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
                set_vec[i] |=> q[i]);                                   // R10
            AST_HOLD_NO_CLR: assert property (@(posedge clk) disable iff (rst)
                (q[i] && !clr_vec[i]) |=> q[i]);                        // R11
            AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
                (clr_vec[i] && !set_vec[i]) |=> !q[i]);                 // R8
        end
    end

endmodule

// File: rtl/bss_top.sv
module bss_top
    import bss_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_tlp_valid,
    input  logic        rx_poisoned,
    input  logic        msg_valid,
    input  logic [1:0]  msg_kind,
    input  logic        cpl_valid,
    input  logic [2:0]  cpl_status,
    input  logic        cpl_own_req,
    input  logic        cpl_rd_data,
    input  logic        par_resp_en,
    input  logic        cfg_wr,
    input  logic [1:0]  cfg_be,
    input  logic [15:0] cfg_wdata,
    output logic [15:0] cfg_rdata
);

    evt_t             evt;
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] q;

    bss_event_decode u_dec (
        .rx_tlp_valid (rx_tlp_valid),
        .rx_poisoned  (rx_poisoned),
        .msg_valid    (msg_valid),
        .msg_kind     (msg_kind),
        .cpl_valid    (cpl_valid),
        .cpl_status   (cpl_status),
        .cpl_own_req  (cpl_own_req),
        .cpl_rd_data  (cpl_rd_data),
        .par_resp_en  (par_resp_en),
        .evt          (evt)
    );

    assign set_vec = evt_to_vec(evt);

    bss_status_store #(
        .W           (REG_W),
        .BW          (BYTE_W),
        .STICKY_MASK (IMPL_MASK)
    ) u_store (
        .clk   (clk),
        .rst   (rst),
        .set_vec (set_vec),
        .wr    (cfg_wr),
        .be    (cfg_be),
        .wdata (cfg_wdata),
        .q     (q)
    );

    assign cfg_rdata = q;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (cfg_rdata == '0));                                     // R1
    AST_POISON_SEEN: assert property (@(posedge clk) disable iff (rst)
        (rx_tlp_valid && rx_poisoned) |=> cfg_rdata[POS_POISON_SEEN]);  // R2
    AST_SYS_ERR_MSG: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind[1]) |=> cfg_rdata[POS_SYS_ERR]);         // R3
    AST_UR_OWN: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && cpl_own_req && cpl_status == 3'b001)
        |=> cfg_rdata[POS_UR_ABORT]);                                   // R4
    AST_CA_OWN: assert property (@(posedge clk) disable iff (rst)
        (cpl_valid && cpl_own_req && cpl_status == 3'b100)
        |=> cfg_rdata[POS_CA_ABORT]);                                   // R5
    AST_RD_POISON_GATED: assert property (@(posedge clk) disable iff (rst)
        (!cfg_rdata[POS_RD_POISON] && !par_resp_en)
        |=> !cfg_rdata[POS_RD_POISON]);                                 // R6
    AST_RD_POISON_IMPLIES_SEEN: assert property (@(posedge clk) disable iff (rst)
        $rose(cfg_rdata[POS_RD_POISON]) |-> cfg_rdata[POS_POISON_SEEN]); // R6
    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (cfg_rdata & ~IMPL_MASK) == '0);                                // R7

endmodule

// File: tb/sim_bss_top.sv
module sim_bss_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] IMPL = 16'hF100;

    logic        clk = 1'b0;
    logic        rst;
    logic        rx_tlp_valid, rx_poisoned, msg_valid, cpl_valid;
    logic [1:0]  msg_kind;
    logic [2:0]  cpl_status;
    logic        cpl_own_req, cpl_rd_data, par_resp_en;
    logic        cfg_wr;
    logic [1:0]  cfg_be;
    logic [15:0] cfg_wdata;
    logic [15:0] cfg_rdata;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bss_top u0 (
        .clk(clk), .rst(rst),
        .rx_tlp_valid(rx_tlp_valid), .rx_poisoned(rx_poisoned),
        .msg_valid(msg_valid), .msg_kind(msg_kind),
        .cpl_valid(cpl_valid), .cpl_status(cpl_status),
        .cpl_own_req(cpl_own_req), .cpl_rd_data(cpl_rd_data),
        .par_resp_en(par_resp_en),
        .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%04h expected=%04h", req, act, exp);
        end
    endtask

    task automatic idle();
        rx_tlp_valid = 0; rx_poisoned = 0; msg_valid = 0; msg_kind = 0;
        cpl_valid = 0; cpl_status = 0; cpl_own_req = 0; cpl_rd_data = 0;
        par_resp_en = 0; cfg_wr = 0; cfg_be = 0; cfg_wdata = 0;
    endtask

    task automatic drive_combo(input logic [11:0] c);
        rx_tlp_valid = c[0];  rx_poisoned = c[1];  msg_valid = c[2];
        msg_kind     = c[4:3]; cpl_valid  = c[5];  cpl_status = c[8:6];
        cpl_own_req  = c[9];  cpl_rd_data = c[10]; par_resp_en = c[11];
    endtask

    function automatic logic [15:0] exp_set(input logic [11:0] c);
        logic [15:0] e;
        e = 16'h0000;
        if (c[0] && c[1])                         e = e + 16'h8000;
        if (c[2] && (c[4:3] >= 2))                e = e + 16'h4000;
        if (c[5] && c[9] && c[8:6] == 3'd1)       e = e + 16'h2000;
        if (c[5] && c[9] && c[8:6] == 3'd4)       e = e + 16'h1000;
        if (c[0] && c[1] && c[5] && c[10] && c[11]) e = e + 16'h0100;
        return e;
    endfunction

    // sets all five implemented bits with two events
    task automatic saturate();
        @(negedge clk);
        idle();
        drive_combo({1'b1, 1'b1, 1'b1, 3'd1, 1'b1, 2'b11, 1'b1, 1'b1, 1'b1});
        @(negedge clk);
        idle();
        drive_combo({1'b0, 1'b0, 1'b1, 3'd4, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0});
        @(negedge clk);
        idle();
    endtask

    task automatic clear_all();
        @(negedge clk);
        idle();
        cfg_wr = 1; cfg_be = 2'b11; cfg_wdata = 16'hFFFF;
        @(negedge clk);
        idle();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        check("R1 reset value", cfg_rdata, 16'h0000);
        rst = 0;
        @(negedge clk);
        check("R1 after reset", cfg_rdata, 16'h0000);

        // R2 R3 R4 R5 R6 R11: every event-input combination from a clear register
        for (int k = 0; k < 4096; k++) begin
            clear_all();
            drive_combo(12'(k));
            #1;
            check("R11 read before event applied", cfg_rdata, 16'h0000);
            @(negedge clk);
            idle();
            check("R2 R3 R4 R5 R6 set pattern", cfg_rdata, exp_set(12'(k)));
            @(negedge clk);
            check("R11 sticky after event", cfg_rdata, exp_set(12'(k)));
        end

        // R10: set and full clear in the same cycle
        for (int k = 0; k < 4096; k++) begin
            saturate();
            check("R10 saturated", cfg_rdata, IMPL);
            drive_combo(12'(k));
            cfg_wr = 1; cfg_be = 2'b11; cfg_wdata = 16'hFFFF;
            @(negedge clk);
            idle();
            check("R10 set wins over clear", cfg_rdata, exp_set(12'(k)));
        end

        // R7 R8 R9: all byte enables and all clear masks of implemented bits
        for (int be = 0; be < 4; be++) begin
            for (int m = 0; m < 32; m++) begin
                logic [15:0] wd;
                logic [15:0] bm;
                wd = 16'h0EFF;
                if (m[0]) wd = wd + 16'h8000;
                if (m[1]) wd = wd + 16'h4000;
                if (m[2]) wd = wd + 16'h2000;
                if (m[3]) wd = wd + 16'h1000;
                if (m[4]) wd = wd + 16'h0100;
                bm = {(be[1] ? 8'hFF : 8'h00), (be[0] ? 8'hFF : 8'h00)};
                saturate();
                cfg_wr = 1; cfg_be = 2'(be); cfg_wdata = wd;
                @(negedge clk);
                idle();
                check("R8 R9 write-one-to-clear", cfg_rdata, IMPL & ~(wd & bm));
                check("R7 reserved read zero", cfg_rdata & ~IMPL, 16'h0000);
            end
        end

        // R9: no byte enable leaves everything
        saturate();
        cfg_wr = 1; cfg_be = 2'b00; cfg_wdata = 16'hFFFF;
        @(negedge clk);
        idle();
        check("R9 no enables no change", cfg_rdata, IMPL);

        // R7: writing zeros to everything changes nothing either
        cfg_wr = 1; cfg_be = 2'b11; cfg_wdata = 16'h0000;
        @(negedge clk);
        idle();
        check("R7 R8 zero write keeps value", cfg_rdata, IMPL);

        // R1: reset clears a saturated register
        rst = 1;
        @(negedge clk);
        rst = 0;
        check("R1 reset clears set bits", cfg_rdata, 16'h0000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule